// File: doc/BRIEF.md
# Per-Channel Word Count Reporter

This block sits beside the merge logic that assembles one event's data from six input channels. It counts how many data words each channel contributes to the current event. At the end of the event it appends two packed count words to the outgoing stream. Ordinary merged data passes through the block with one register stage. Each channel raises its own word-strobe bit in every cycle in which it contributes a word, and the block keeps a 7-bit count for that channel.

The merged stream marks end-of-event words with a flag. When the second flagged word of an event has gone out, the block takes over the output bus for two cycles. In the first cycle it sends the counts of channels 0 to 3 on a dedicated strobe. In the second cycle it sends the counts of channels 4 and 5 on another dedicated strobe. The ordinary data strobe is forced low in both cycles. The counters then clear for the next event.

A 6-bit enable mask chooses which channels are counted. A disabled channel always reports zero. The mask is taken from the configuration input during synchronous reset, so the mask is changed by writing the configuration register and then resetting the block. The configuration register outside the block holds all ones after power-up, so every channel is enabled on the first reset.

Top module: `wcount_reporter`

## Requirements
- R1: Mask bit n enables channel n, with value 1 meaning enabled. Bits 0 to 2 are card 1 channels 1 to 3, and bits 3 to 5 are card 2 channels 1 to 3. A disabled channel reports a count of zero in its field.
- R2: The mask in use is the value of `cfg_mask_i` captured while `rst_i` is high. A change of `cfg_mask_i` outside reset has no effect until the next reset. All ones enables every channel.
- R3: Each channel counter adds one in every counting cycle in which its `ch_word_i` bit is high. The counter is 7 bits wide and holds at 127 instead of wrapping.
- R4: Outside the two report cycles, `out_data_o` and `out_stb_o` equal `data_i` and `data_stb_i` from one clock earlier.
- R5: Word 1 comes out in the cycle after the output cycle that carries the second end-of-event word. Word 1 has bits 31:30 zero, count 3 in 29:23, count 2 in 22:16, bits 15:14 zero, count 1 in 13:7 and count 0 in 6:0. `spare0_stb_o` is high in that cycle and `spare1_stb_o` is low.
- R6: Word 2 comes out in the next cycle. Word 2 has count 5 in bits 13:7, count 4 in bits 6:0, and every other bit zero. `spare1_stb_o` is high in that cycle and `spare0_stb_o` is low.
- R7: `out_stb_o` is low in both report cycles. Input data presented in those cycles is dropped.
- R8: The counters clear after word 2. Channel strobes and end-of-event flags seen in the two report cycles are ignored.
- R9: During and right after reset, every output is zero.
- R10: `eoe_i` counts only together with `data_stb_i`. The first end-of-event word of an event passes through without starting a report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high; also loads the mask |
| cfg_mask_i | input | 6 | Channel enable configuration, sampled during reset |
| ch_word_i | input | 6 | Per-channel word strobe for the current cycle |
| data_i | input | 32 | Merged data word |
| data_stb_i | input | 1 | Merged data valid |
| eoe_i | input | 1 | Current data word is an end-of-event word |
| out_data_o | output | 32 | Output bus: data or packed count words |
| out_stb_o | output | 1 | Output data strobe |
| spare0_stb_o | output | 1 | Qualifies word 1 |
| spare1_stb_o | output | 1 | Qualifies word 2 |

## Verification
Suppose the second end-of-event word is presented at clock edge k. The pass-through copy of that word is due after edge k. Word 1 is due after edge k+1 and word 2 after edge k+2. An ordinary data word is due one edge after it is presented. The bench drives inputs on falling edges and reads the outputs on the falling edge that follows the edge at which each result is due, so every sample lands on the cycle the requirements fix. The bench also drives junk data, channel strobes and end-of-event flags during both report cycles. The next event must then show exactly the counts expected from a cleared start.

// File: rtl/wcr_pkg.sv
package wcr_pkg;
    localparam int NCH       = 6;
    localparam int CNT_W     = 7;
    localparam int BUS_W     = 32;
    localparam int HALF_W    = BUS_W / 2;
    localparam int PER_WORD  = 4;
    localparam int CNTS_W    = NCH * CNT_W;

    typedef enum logic [1:0] {
        PH_RUN = 2'd0,
        PH_W1  = 2'd1,
        PH_W2  = 2'd2
    } phase_e;

    // Four counts per word: two per 16-bit half, at the low end of each half.
    function automatic logic [BUS_W-1:0] pack_word(input logic [CNTS_W-1:0] cnts,
                                                    input int unsigned      widx);
        logic [BUS_W-1:0] r;
        r = '0;
        for (int k = 0; k < PER_WORD; k++) begin
            int unsigned ch;
            ch = widx * PER_WORD + k;
            if (ch < NCH)
                r[(k / 2) * HALF_W + (k % 2) * CNT_W +: CNT_W] = cnts[ch * CNT_W +: CNT_W];
        end
        return r;
    endfunction
endpackage

// File: rtl/wcr_chan_cnt.sv
module wcr_chan_cnt #(
    parameter int CNT_W = 7
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             en_i,
    input  logic             inc_i,
    input  logic             hold_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i)
            s_d.cnt = '0;
        else if (en_i && inc_i && !hold_i && (s_q.cnt != CNT_MAX))
            s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '0;
        else       s_q <= s_d;
    end

    // A disabled channel reports zero whatever the counter holds.
    assign cnt_o = en_i ? s_q.cnt : '0;
endmodule

// File: rtl/wcr_seq.sv
module wcr_seq
    import wcr_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  logic   stb_i,
    input  logic   eoe_i,
    output phase_e phase_o
);
    typedef struct packed {
        phase_e phase;
        logic   seen;
    } seq_state_t;

    seq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_RUN: begin
                if (stb_i && eoe_i) begin
                    if (s_q.seen) begin
                        s_d.phase = PH_W1;
                        s_d.seen  = 1'b0;
                    end else begin
                        s_d.seen  = 1'b1;
                    end
                end
            end
            PH_W1:   s_d.phase = PH_W2;
            PH_W2:   s_d.phase = PH_RUN;
            default: s_d.phase = PH_RUN;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) s_q <= '{phase: PH_RUN, seen: 1'b0};
        else       s_q <= s_d;
    end

    assign phase_o = s_q.phase;
endmodule

// File: rtl/wcount_reporter.sv
module wcount_reporter
    import wcr_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [NCH-1:0]   cfg_mask_i,
    input  logic [NCH-1:0]   ch_word_i,
    input  logic [BUS_W-1:0] data_i,
    input  logic             data_stb_i,
    input  logic             eoe_i,
    output logic [BUS_W-1:0] out_data_o,
    output logic             out_stb_o,
    output logic             spare0_stb_o,
    output logic             spare1_stb_o
);
    typedef struct packed {
        logic [NCH-1:0]   mask;
        logic [BUS_W-1:0] data;
        logic             stb;
        logic             sp0;
        logic             sp1;
    } out_state_t;

    out_state_t    s_d, s_q;
    phase_e        phase;
    logic [CNTS_W-1:0] cnts;
    logic          hold;
    logic          clr;

    assign hold = (phase != PH_RUN);
    assign clr  = (phase == PH_W2);

    wcr_seq u_seq (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .stb_i   (data_stb_i),
        .eoe_i   (eoe_i),
        .phase_o (phase)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        wcr_chan_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .en_i   (s_q.mask[g]),
            .inc_i  (ch_word_i[g]),
            .hold_i (hold),
            .clr_i  (clr),
            .cnt_o  (cnts[g*CNT_W +: CNT_W])
        );
    end

    always_comb begin
        s_d      = s_q;
        s_d.sp0  = 1'b0;
        s_d.sp1  = 1'b0;
        unique case (phase)
            PH_W1: begin
                s_d.data = pack_word(cnts, 0);
                s_d.stb  = 1'b0;
                s_d.sp0  = 1'b1;
            end
            PH_W2: begin
                s_d.data = pack_word(cnts, 1);
                s_d.stb  = 1'b0;
                s_d.sp1  = 1'b1;
            end
            default: begin
                s_d.data = data_i;
                s_d.stb  = data_stb_i;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q      <= '0;
            s_q.mask <= cfg_mask_i;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_data_o   = s_q.data;
    assign out_stb_o    = s_q.stb;
    assign spare0_stb_o = s_q.sp0;
    assign spare1_stb_o = s_q.sp1;
endmodule

module wcount_reporter_chk
    import wcr_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic [BUS_W-1:0] out_data_o,
    input logic             out_stb_o,
    input logic             spare0_stb_o,
    input logic             spare1_stb_o
);
    // R7
    stb_exclusive_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !(out_stb_o && (spare0_stb_o || spare1_stb_o)));

    // R6
    w2_follows_w1_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        spare0_stb_o |=> spare1_stb_o);

    // R6
    w2_after_w1_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        spare1_stb_o |-> $past(spare0_stb_o));

    // R5
    w1_gaps_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        spare0_stb_o |-> (out_data_o[31:30] == 2'b00 && out_data_o[15:14] == 2'b00));

    // R6
    w2_upper_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        spare1_stb_o |-> (out_data_o[31:14] == '0));

    // R5
    spare_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({spare0_stb_o, spare1_stb_o}));
endmodule

bind wcount_reporter wcount_reporter_chk u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .out_data_o   (out_data_o),
    .out_stb_o    (out_stb_o),
    .spare0_stb_o (spare0_stb_o),
    .spare1_stb_o (spare1_stb_o)
);

// File: tb/wcount_reporter_tb_top.sv
module wcount_reporter_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic [5:0]  cfg_mask_i = 6'h3F;
    logic [5:0]  ch_word_i = '0;
    logic [31:0] data_i = '0;
    logic        data_stb_i = 1'b0;
    logic        eoe_i = 1'b0;
    logic [31:0] out_data_o;
    logic        out_stb_o, spare0_stb_o, spare1_stb_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk_i = ~clk_i;

    wcount_reporter dut_i (
        .clk_i(clk_i), .rst_i(rst_i), .cfg_mask_i(cfg_mask_i), .ch_word_i(ch_word_i),
        .data_i(data_i), .data_stb_i(data_stb_i), .eoe_i(eoe_i),
        .out_data_o(out_data_o), .out_stb_o(out_stb_o),
        .spare0_stb_o(spare0_stb_o), .spare1_stb_o(spare1_stb_o)
    );

    // Vector: {mask[5:0], c5, c4, c3, c2, c1, c0}, 8 bits per word count.
    localparam logic [53:0] VEC [6] = '{
        {6'h3F, 8'd6,   8'd5,   8'd4,   8'd3,   8'd2,   8'd1},
        {6'h3F, 8'd127, 8'd1,   8'd100, 8'd64,  8'd0,   8'd127},
        {6'h15, 8'd60,  8'd50,  8'd40,  8'd30,  8'd20,  8'd10},
        {6'h2A, 8'd5,   8'd5,   8'd5,   8'd5,   8'd5,   8'd5},
        {6'h3F, 8'd0,   8'd0,   8'd0,   8'd128, 8'd129, 8'd130},
        {6'h00, 8'd9,   8'd9,   8'd9,   8'd9,   8'd9,   8'd9}
    };

    function automatic logic [6:0] exp_cnt(input logic [5:0] m, input logic [47:0] c, input int ch);
        int v;
        v = int'(c[ch*8 +: 8]);
        if (!m[ch]) return 7'd0;
        return (v > 127) ? 7'd127 : v[6:0];
    endfunction

    function automatic logic [34:0] exp_w1(input logic [5:0] m, input logic [47:0] c);
        return {1'b0, 1'b1, 1'b0, 2'b00, exp_cnt(m, c, 3), exp_cnt(m, c, 2),
                2'b00, exp_cnt(m, c, 1), exp_cnt(m, c, 0)};
    endfunction

    function automatic logic [34:0] exp_w2(input logic [5:0] m, input logic [47:0] c);
        return {1'b0, 1'b0, 1'b1, 18'd0, exp_cnt(m, c, 5), exp_cnt(m, c, 4)};
    endfunction

    function automatic logic [34:0] outs();
        return {out_stb_o, spare0_stb_o, spare1_stb_o, out_data_o};
    endfunction

    task automatic chk(input string req, input logic [34:0] act, input logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual {stb,sp0,sp1,data}=%h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [5:0] m);
        @(negedge clk_i);
        rst_i = 1'b1; cfg_mask_i = m;
        ch_word_i = '0; data_i = '0; data_stb_i = 1'b0; eoe_i = 1'b0;
        repeat (2) @(negedge clk_i);
        rst_i = 1'b0;
    endtask

    task automatic send_event(input logic [47:0] c, output logic [34:0] r_e2,
                              output logic [34:0] r_w1, output logic [34:0] r_w2);
        int maxc;
        maxc = 0;
        for (int ch = 0; ch < 6; ch++)
            if (int'(c[ch*8 +: 8]) > maxc) maxc = int'(c[ch*8 +: 8]);
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk_i);
            data_i = 32'h0D00_0000 + i; data_stb_i = 1'b1; eoe_i = 1'b0;
            for (int ch = 0; ch < 6; ch++) ch_word_i[ch] = (i < int'(c[ch*8 +: 8]));
        end
        @(negedge clk_i);
        data_i = 32'hE0E0_0001; data_stb_i = 1'b1; eoe_i = 1'b1; ch_word_i = '0;
        @(negedge clk_i);
        data_i = 32'hE0E0_0002;
        @(negedge clk_i);
        r_e2 = outs();
        data_i = 32'hBAD0_BAD0; data_stb_i = 1'b1; eoe_i = 1'b1; ch_word_i = 6'h3F;
        @(negedge clk_i);
        r_w1 = outs();
        @(negedge clk_i);
        r_w2 = outs();
        data_i = '0; data_stb_i = 1'b0; eoe_i = 1'b0; ch_word_i = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [34:0] e2, w1, w2;
        logic [34:0] E2_EXP;
        E2_EXP = {1'b1, 1'b0, 1'b0, 32'hE0E0_0002};

        // Reset state (R9)
        do_reset(6'h3F);
        chk("R9 reset outputs zero", outs(), 35'd0);

        // Vector table: R1 R3 R5 R6 R7 R10
        for (int v = 0; v < 6; v++) begin
            do_reset(VEC[v][53:48]);
            send_event(VEC[v][47:0], e2, w1, w2);
            chk("R10 second EOE passes, no report yet", e2, E2_EXP);
            chk("R5 R1 R3 word1 and spare0", w1, exp_w1(VEC[v][53:48], VEC[v][47:0]));
            chk("R6 R1 R3 R7 word2 and spare1", w2, exp_w2(VEC[v][53:48], VEC[v][47:0]));
        end

        // Pass-through (R4)
        do_reset(6'h3F);
        @(negedge clk_i);
        data_i = 32'h1234_5678; data_stb_i = 1'b1;
        @(negedge clk_i);
        chk("R4 data passes one cycle later", outs(), {1'b1, 2'b00, 32'h1234_5678});
        data_stb_i = 1'b0; data_i = 32'h0000_00AA;
        @(negedge clk_i);
        chk("R4 idle word passes with strobe low", outs(), {1'b0, 2'b00, 32'h0000_00AA});
        data_i = '0;

        // EOE flag without data strobe does not count (R10)
        do_reset(6'h3F);
        @(negedge clk_i);
        eoe_i = 1'b1; data_stb_i = 1'b0;
        @(negedge clk_i);
        eoe_i = 1'b0;
        send_event({8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd2}, e2, w1, w2);
        chk("R10 unstrobed EOE ignored", e2, E2_EXP);
        chk("R10 word1 after true second EOE", w1, exp_w1(6'h3F, {40'd0, 8'd2}));

        // Clear after word 2 and report-cycle inputs ignored (R8)
        do_reset(6'h3F);
        send_event({8'd3, 8'd3, 8'd3, 8'd3, 8'd3, 8'd3}, e2, w1, w2);
        send_event(48'd0, e2, w1, w2);
        chk("R8 next event second EOE on time", e2, E2_EXP);
        chk("R8 counts cleared word1", w1, exp_w1(6'h3F, 48'd0));
        chk("R8 counts cleared word2", w2, exp_w2(6'h3F, 48'd0));

        // Mask change without reset has no effect (R2)
        do_reset(6'h3F);
        @(negedge clk_i);
        cfg_mask_i = 6'h00;
        send_event({8'd4, 8'd4, 8'd4, 8'd4, 8'd4, 8'd4}, e2, w1, w2);
        chk("R2 mask unchanged without reset word1", w1, exp_w1(6'h3F, {6{8'd4}}));
        chk("R2 mask unchanged without reset word2", w2, exp_w2(6'h3F, {6{8'd4}}));
        do_reset(6'h00);
        send_event({8'd4, 8'd4, 8'd4, 8'd4, 8'd4, 8'd4}, e2, w1, w2);
        chk("R2 new mask applied after reset", w1, exp_w1(6'h00, {6{8'd4}}));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule